// File: doc/BRIEF.md
# Bank Conflict Serializer

This block sits in front of a multi-bank scratchpad and turns one vector instruction into a sequence of conflict-free bank accesses. Every lane brings a valid bit, a bank index and a full word address. When the instruction is accepted, the block captures all lanes. It then presents one subset of lanes per cycle. Within a subset no bank is asked for two different words. Lanes that name the same bank and the same address count as one request: they are granted together, so the bank's single read fans out to all of them.

Each issue cycle the block drives a grant bit per lane. For the crossbar it also drives, per bank, an active bit and the index of the lane that bank serves. It reports the total number of issue cycles the instruction needs. A last flag marks the final subset, so a downstream collector knows when the result vector is complete. While further subsets remain, a busy flag blocks new instructions. Instructions without conflicts flow at one per cycle.

The controller has two states. In `SER_IDLE` nothing is pending. In `SER_ISSUE` a subset is presented. The transitions are:

- *accept*: `SER_IDLE` goes to `SER_ISSUE`.
- *continue*: `SER_ISSUE` stays in `SER_ISSUE` when this is not the last subset.
- *chain*: `SER_ISSUE` stays in `SER_ISSUE` when this is the last subset and a new instruction is accepted in the same cycle.
- *drain*: `SER_ISSUE` goes to `SER_IDLE` when this is the last subset and no new instruction arrives.

Top module: `bank_serializer`

## Requirements
- R1: Two valid lanes with the same bank index and different addresses are never granted in the same cycle. Valid lanes with the same bank index and the same address are always granted in the same cycle (broadcast).
- R2: An instruction whose busiest bank holds n distinct addresses among its valid lanes is issued in exactly n consecutive issue cycles. `cycles_o` equals n during all of them.
- R3: `busy_o` is high on every issue cycle except the last one of an instruction, and low otherwise. `ready_o` is always the inverse of `busy_o`.
- R4: In each issue cycle, each bank serves at most one address. For bank b, `bank_act_o[b]` is high when that bank serves a lane, and `bank_sel_o[b*LI_W +: LI_W]` holds the served lane's index. Both fields are 0 for an inactive bank and outside issue cycles.
- R5: When no bank holds two distinct addresses, all valid lanes are granted in the single issue cycle, and `busy_o` never rises.
- R6: Within a bank, the pending lane with the lowest index is served first, together with every pending lane sharing its address.
- R7: `last_o` is high exactly on the final issue cycle of each instruction.
- R8: A lane whose valid bit is low is never granted and does not add to the cycle count.
- R9: When `start_i` is high while `busy_o` is high, it has no effect: no extra issue cycles occur and the running instruction continues unchanged.
- R10: `start_i` is sampled at a rising edge with `ready_o` high. The first subset is presented in the following cycle. Conflict-free instructions can be accepted on consecutive cycles.
- R11: An accepted instruction with no valid lanes gives one issue cycle with no grants, `last_o` high and `cycles_o` equal to 1.
- R12: After reset, `issue_o`, `busy_o`, `last_o` and all grants are low, and `ready_o` is high.

Lane i uses `lane_bank_i[i*BI_W +: BI_W]` and `lane_addr_i[i*ADDR_W +: ADDR_W]`. `BANKS` must be a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to accept the instruction on the lane inputs |
| lane_vld_i | input | LANES | Per-lane participation bit |
| lane_bank_i | input | LANES*BI_W | Per-lane bank index |
| lane_addr_i | input | LANES*ADDR_W | Per-lane word address |
| ready_o | output | 1 | A new instruction can be accepted |
| busy_o | output | 1 | Further subsets remain after this cycle |
| issue_o | output | 1 | A subset is presented this cycle |
| last_o | output | 1 | The presented subset is the final one |
| cycles_o | output | CNT_W | Issue cycles needed by the current instruction |
| grant_o | output | LANES | Lanes served this cycle |
| bank_act_o | output | BANKS | Banks in use this cycle |
| bank_sel_o | output | BANKS*LI_W | Per-bank index of the served lane |

## Verification
Most corrupted internal state shows at the ports within one issue cycle:

- A stale or wrongly cleared pending mask shows up either as a lane granted twice, or as an instruction that ends with `last_o` before every lane was served. In both cases the next subset on the grant bus is wrong at once.
- A wrong leader choice moves a lane into a different cycle, which the per-cycle grant and bank-select comparison exposes.
- A miscounted way number appears in `cycles_o` on the first issue cycle.
- A controller that loses or repeats a state shifts the cycle in which subsets appear relative to acceptance, which the timestamp on every expected item reveals.

// File: rtl/bser_pkg.sv
package bser_pkg;

    typedef enum logic [0:0] {
        SER_IDLE  = 1'b0,
        SER_ISSUE = 1'b1
    } ser_state_e;

    function automatic int unsigned bser_clog2(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((32'd1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/bser_way_count.sv
module bser_way_count #(
    parameter int LANES  = 8,
    parameter int BANKS  = 4,
    parameter int ADDR_W = 12,
    parameter int BI_W   = 2,
    parameter int CNT_W  = 4
) (
    input  logic [LANES-1:0]        vld_i,
    input  logic [LANES*BI_W-1:0]   bank_i,
    input  logic [LANES*ADDR_W-1:0] addr_i,
    output logic [CNT_W-1:0]        ways_o
);

    // a lane is a "first" when no lower valid lane shares its bank and word
    logic [LANES-1:0] first_w;
    logic [CNT_W-1:0] per_bank_w [BANKS];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            first_w[i] = vld_i[i];
            for (int j = 0; j < i; j++) begin
                if (vld_i[j]
                    && bank_i[j*BI_W +: BI_W] == bank_i[i*BI_W +: BI_W]
                    && addr_i[j*ADDR_W +: ADDR_W] == addr_i[i*ADDR_W +: ADDR_W])
                    first_w[i] = 1'b0;
            end
        end
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            always_comb begin
                per_bank_w[b] = '0;
                for (int i = 0; i < LANES; i++) begin
                    if (first_w[i] && bank_i[i*BI_W +: BI_W] == BI_W'(b))
                        per_bank_w[b] = per_bank_w[b] + 1'b1;
                end
            end
        end
    endgenerate

    always_comb begin
        ways_o = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (per_bank_w[b] > ways_o) ways_o = per_bank_w[b];
        end
    end

endmodule

// File: rtl/bser_subset_pick.sv
module bser_subset_pick #(
    parameter int LANES  = 8,
    parameter int BANKS  = 4,
    parameter int ADDR_W = 12,
    parameter int BI_W   = 2,
    parameter int LI_W   = 3
) (
    input  logic [LANES-1:0]        pend_i,
    input  logic [LANES*BI_W-1:0]   bank_i,
    input  logic [LANES*ADDR_W-1:0] addr_i,
    output logic [LANES-1:0]        grant_o,
    output logic [BANKS-1:0]        act_o,
    output logic [BANKS*LI_W-1:0]   sel_o
);

    logic [LI_W-1:0] lead_w [BANKS];

    // per bank: lowest-index pending lane leads (scan from top, last hit wins)
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            act_o[b]  = 1'b0;
            lead_w[b] = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
                if (pend_i[i] && bank_i[i*BI_W +: BI_W] == BI_W'(b)) begin
                    act_o[b]  = 1'b1;
                    lead_w[b] = LI_W'(i);
                end
            end
        end
    end

    // a pending lane follows its bank's leader when it names the same word
    always_comb begin
        logic [BI_W-1:0] bi;
        logic [LI_W-1:0] ld;
        for (int i = 0; i < LANES; i++) begin
            bi = bank_i[i*BI_W +: BI_W];
            ld = lead_w[bi];
            grant_o[i] = pend_i[i]
                && (addr_i[i*ADDR_W +: ADDR_W] == addr_i[int'(ld)*ADDR_W +: ADDR_W]);
        end
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_pack
            assign sel_o[b*LI_W +: LI_W] = lead_w[b];
        end
    endgenerate

endmodule

// File: rtl/bank_serializer.sv
module bank_serializer
    import bser_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int BANKS  = 4,
    parameter int ADDR_W = 12,
    localparam int BI_W  = bser_clog2(BANKS),
    localparam int LI_W  = bser_clog2(LANES),
    localparam int CNT_W = bser_clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [LANES-1:0]        lane_vld_i,
    input  logic [LANES*BI_W-1:0]   lane_bank_i,
    input  logic [LANES*ADDR_W-1:0] lane_addr_i,
    output logic                    ready_o,
    output logic                    busy_o,
    output logic                    issue_o,
    output logic                    last_o,
    output logic [CNT_W-1:0]        cycles_o,
    output logic [LANES-1:0]        grant_o,
    output logic [BANKS-1:0]        bank_act_o,
    output logic [BANKS*LI_W-1:0]   bank_sel_o
);

    ser_state_e st_q, st_d;

    logic [LANES-1:0]        pend_q;
    logic [LANES*BI_W-1:0]   bank_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]        ways_q;
    logic [CNT_W-1:0]        left_q;

    logic [CNT_W-1:0]        way_cnt;
    logic [CNT_W-1:0]        way_load;
    logic [LANES-1:0]        grant_w;
    logic [BANKS-1:0]        act_w;
    logic [BANKS*LI_W-1:0]   sel_w;
    logic                    accept;
    logic                    final_w;

    bser_way_count #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ADDR_W(ADDR_W),
        .BI_W  (BI_W),
        .CNT_W (CNT_W)
    ) u_count (
        .vld_i (lane_vld_i),
        .bank_i(lane_bank_i),
        .addr_i(lane_addr_i),
        .ways_o(way_cnt)
    );

    bser_subset_pick #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ADDR_W(ADDR_W),
        .BI_W  (BI_W),
        .LI_W  (LI_W)
    ) u_pick (
        .pend_i (pend_q),
        .bank_i (bank_q),
        .addr_i (addr_q),
        .grant_o(grant_w),
        .act_o  (act_w),
        .sel_o  (sel_w)
    );

    // an empty instruction still takes one issue cycle
    assign way_load = (way_cnt == '0) ? CNT_W'(1) : way_cnt;
    assign final_w  = ((pend_q & ~grant_w) == '0);
    assign accept   = start_i && ready_o;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SER_IDLE: begin
                if (accept) st_d = SER_ISSUE;          // accept
            end
            SER_ISSUE: begin
                if (!final_w)    st_d = SER_ISSUE;     // continue
                else if (accept) st_d = SER_ISSUE;     // chain
                else             st_d = SER_IDLE;      // drain
            end
            default: st_d = SER_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SER_IDLE;
        else        st_q <= st_d;
    end

    // instruction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            bank_q <= '0;
            addr_q <= '0;
            ways_q <= '0;
            left_q <= '0;
        end else if (accept) begin
            pend_q <= lane_vld_i;
            bank_q <= lane_bank_i;
            addr_q <= lane_addr_i;
            ways_q <= way_load;
            left_q <= way_load;
        end else if (st_q == SER_ISSUE) begin
            pend_q <= pend_q & ~grant_w;
            left_q <= left_q - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        issue_o    = 1'b0;
        last_o     = 1'b0;
        busy_o     = 1'b0;
        cycles_o   = '0;
        grant_o    = '0;
        bank_act_o = '0;
        bank_sel_o = '0;
        unique case (st_q)
            SER_IDLE: begin
            end
            SER_ISSUE: begin
                issue_o    = 1'b1;
                last_o     = final_w;
                busy_o     = !final_w;
                cycles_o   = ways_q;
                grant_o    = grant_w;
                bank_act_o = act_w;
                bank_sel_o = sel_w;
            end
            default: begin
            end
        endcase
        ready_o = !busy_o;
    end

    // ---------------- assertions ----------------
    AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o && last_o |-> left_q == CNT_W'(1)); // R2

    AST_MORE_TO_COME: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o && !last_o |-> left_q > CNT_W'(1)); // R7

    AST_CYCLES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o && !last_o |=> issue_o && $stable(cycles_o)); // R2

    AST_BUSY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> issue_o); // R3

    AST_NO_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && way_cnt <= CNT_W'(1) |=> !busy_o && last_o); // R5

    AST_INVALID_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (grant_o & ~$past(lane_vld_i)) == '0); // R8

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> left_q == $past(left_q) - CNT_W'(1)); // R9

    AST_FIRST_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> issue_o && cycles_o == left_q); // R10

    AST_ONEHOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_o |-> grant_o == '0 && bank_act_o == '0); // R4

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
            AST_BANK_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
                issue_o && grant_o[i] |-> bank_act_o[bank_q[i*BI_W +: BI_W]]); // R4

            AST_LEADER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
                issue_o && grant_o[i]
                |-> bank_sel_o[int'(bank_q[i*BI_W +: BI_W])*LI_W +: LI_W] <= LI_W'(i)); // R6
        end
    endgenerate

endmodule

// File: tb/sim_bank_serializer.sv
module sim_bank_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 8;
    localparam int BANKS  = 4;
    localparam int ADDR_W = 12;
    localparam int BI_W   = 2;
    localparam int LI_W   = 3;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic [LANES-1:0]      grant;
        logic                  last;
        logic                  busy;
        logic [CNT_W-1:0]      cycles;
        logic [BANKS-1:0]      act;
        logic [BANKS*LI_W-1:0] sel;
        int                    due;
    } item_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [LANES-1:0]        lane_vld_i = '0;
    logic [LANES*BI_W-1:0]   lane_bank_i = '0;
    logic [LANES*ADDR_W-1:0] lane_addr_i = '0;
    logic                    ready_o, busy_o, issue_o, last_o;
    logic [CNT_W-1:0]        cycles_o;
    logic [LANES-1:0]        grant_o;
    logic [BANKS-1:0]        bank_act_o;
    logic [BANKS*LI_W-1:0]   bank_sel_o;

    int     errors = 0;
    int     checks = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    item_t  exp_q[$];

    bank_serializer #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .lane_vld_i(lane_vld_i), .lane_bank_i(lane_bank_i), .lane_addr_i(lane_addr_i),
        .ready_o(ready_o), .busy_o(busy_o), .issue_o(issue_o), .last_o(last_o),
        .cycles_o(cycles_o), .grant_o(grant_o), .bank_act_o(bank_act_o),
        .bank_sel_o(bank_sel_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // reference: repeatedly serve, per bank, the lowest pending lane and its same-word peers
    task automatic push_expect(input logic [LANES-1:0] vld, input logic [LANES*BI_W-1:0] bk,
                               input logic [LANES*ADDR_W-1:0] ad, input int base);
        logic [LANES-1:0]      g_l [LANES+1];
        logic [BANKS-1:0]      a_l [LANES+1];
        logic [BANKS*LI_W-1:0] s_l [LANES+1];
        logic [LANES-1:0]      pend;
        int n;
        item_t it;
        pend = vld;
        n = 0;
        do begin
            g_l[n] = '0; a_l[n] = '0; s_l[n] = '0;
            for (int b = 0; b < BANKS; b++) begin
                for (int i = 0; i < LANES; i++) begin
                    if (!a_l[n][b] && pend[i] && bk[i*BI_W +: BI_W] == BI_W'(b)) begin
                        a_l[n][b] = 1'b1;
                        s_l[n][b*LI_W +: LI_W] = LI_W'(i);
                        for (int k = i; k < LANES; k++)
                            if (pend[k] && bk[k*BI_W +: BI_W] == BI_W'(b)
                                && ad[k*ADDR_W +: ADDR_W] == ad[i*ADDR_W +: ADDR_W])
                                g_l[n][k] = 1'b1;
                    end
                end
            end
            pend = pend & ~g_l[n];
            n++;
        end while (pend != '0);
        for (int k = 0; k < n; k++) begin
            it.grant  = g_l[k];
            it.act    = a_l[k];
            it.sel    = s_l[k];
            it.last   = (k == n - 1);
            it.busy   = (k != n - 1);
            it.cycles = CNT_W'(n);
            it.due    = base + 1 + k;
            exp_q.push_back(it);
        end
    endtask

    // driver: waits for ready, presents one instruction for one edge
    task automatic send(input logic [LANES-1:0] vld, input logic [LANES*BI_W-1:0] bk,
                        input logic [LANES*ADDR_W-1:0] ad);
        while (!ready_o) @(negedge clk);
        push_expect(vld, bk, ad, cyc);
        lane_vld_i  = vld;
        lane_bank_i = bk;
        lane_addr_i = ad;
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    function automatic logic [LANES*BI_W-1:0] banks_of(input int b0, b1, b2, b3, b4, b5, b6, b7);
        logic [LANES*BI_W-1:0] r;
        r = {BI_W'(b7), BI_W'(b6), BI_W'(b5), BI_W'(b4), BI_W'(b3), BI_W'(b2), BI_W'(b1), BI_W'(b0)};
        return r;
    endfunction

    function automatic logic [LANES*ADDR_W-1:0] addrs_of(input int a0, a1, a2, a3, a4, a5, a6, a7);
        logic [LANES*ADDR_W-1:0] r;
        r = {ADDR_W'(a7), ADDR_W'(a6), ADDR_W'(a5), ADDR_W'(a4),
             ADDR_W'(a3), ADDR_W'(a2), ADDR_W'(a1), ADDR_W'(a0)};
        return r;
    endfunction

    // monitor: every issue cycle pops one expected subset
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", "ready_o vs busy_o", 64'(ready_o), 64'(!busy_o));
            if (issue_o) begin
                if (exp_q.size() == 0) begin
                    check("R9", "unexpected issue", 64'(grant_o), 64'hDEAD);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check("R1", "grant_o (R6 order)", 64'(grant_o), 64'(e.grant));
                    check("R4", "bank_act_o", 64'(bank_act_o), 64'(e.act));
                    check("R4", "bank_sel_o", 64'(bank_sel_o), 64'(e.sel));
                    check("R7", "last_o", 64'(last_o), 64'(e.last));
                    check("R3", "busy_o", 64'(busy_o), 64'(e.busy));
                    check("R2", "cycles_o", 64'(cycles_o), 64'(e.cycles));
                    check("R10", "issue cycle", 64'(cyc), 64'(e.due));
                end
            end else begin
                check("R4", "idle bank fields", 64'({bank_act_o, bank_sel_o, grant_o}), 64'(0));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset issue/busy/last", 64'({issue_o, busy_o, last_o}), 64'(0));
        check("R12", "reset ready", 64'(ready_o), 64'(1));
        check("R12", "reset grants", 64'(grant_o), 64'(0));

        // R5: distinct banks, no conflict
        send(8'h0F, banks_of(0,1,2,3,0,0,0,0), addrs_of(5,6,7,8,0,0,0,0));
        // R1/R5 broadcast: lanes 4..7 repeat words of 0..3
        send(8'hFF, banks_of(0,1,2,3,0,1,2,3), addrs_of(9,9,4,4,9,9,4,4));
        // R2/R6: one bank, four distinct words in pairs -> 4 cycles
        send(8'hFF, banks_of(2,2,2,2,2,2,2,2), addrs_of(30,10,20,10,40,30,20,40));
        // R2: full 8-way conflict
        send(8'hFF, banks_of(1,1,1,1,1,1,1,1), addrs_of(1,2,3,4,5,6,7,8));
        // R8: invalid lanes would conflict but are excluded
        send(8'b0101_0101, banks_of(0,0,1,1,2,2,3,3), addrs_of(1,2,3,4,5,6,7,8));
        // R11: no valid lanes at all
        send(8'h00, banks_of(1,1,1,1,1,1,1,1), addrs_of(1,2,3,4,5,6,7,8));
        // R10: back-to-back conflict-free
        send(8'h03, banks_of(0,1,0,0,0,0,0,0), addrs_of(1,1,0,0,0,0,0,0));
        send(8'h0C, banks_of(0,0,2,3,0,0,0,0), addrs_of(0,0,2,2,0,0,0,0));
        send(8'hF0, banks_of(0,0,0,0,3,3,3,3), addrs_of(0,0,0,0,7,7,7,7));
        // R9: start during busy is ignored
        send(8'hFF, banks_of(0,0,0,1,1,1,2,2), addrs_of(1,2,3,4,5,4,6,6));
        lane_vld_i  = 8'hFF;
        lane_bank_i = banks_of(3,3,3,3,3,3,3,3);
        lane_addr_i = addrs_of(1,2,3,4,5,6,7,8);
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", "no issue after ignored start", 64'(issue_o), 64'(0));

        // mixed patterns
        for (int t = 0; t < 80; t++) begin
            logic [LANES-1:0]        v;
            logic [LANES*BI_W-1:0]   bk;
            logic [LANES*ADDR_W-1:0] ad;
            v = LANES'($urandom);
            for (int i = 0; i < LANES; i++) begin
                bk[i*BI_W +: BI_W]     = BI_W'($urandom % BANKS);
                ad[i*ADDR_W +: ADDR_W] = ADDR_W'($urandom % 3);
            end
            send(v, bk, ad);
            if ($urandom % 4 == 0) @(negedge clk);
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2", "queue drained", 64'(exp_q.size()), 64'(0));
        check("R7", "idle after drain", 64'({issue_o, last_o}), 64'(0));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule